// File: doc/BRIEF.md
# Cascadable Presettable Up/Down Counter Stage

This block is one stage of a binary counter that steps up or down by one on each rising clock edge. Stepping is enabled by an active-low enable input. A direction input selects whether the stage increments or decrements. Two level-sensitive controls act on the count without waiting for the clock:
- a clear, which forces the count to zero;
- a parallel load, which copies the jam inputs into the count.

The clear wins over the load.

An active-low carry output reports that the stage sits at its terminal value for the current direction while its own enable is active. Wider counters are built from several stages that share one clock. Each stage's carry output feeds the enable of the next more significant stage, so the higher stage advances only on the edge where every lower stage wraps. The path from the enable input to the carry output is purely combinational, so a carry ripples through the whole chain within one cycle.

A stage may also be chained by feeding its carry output into the next stage's clock. In that arrangement the direction input should change only while the clock is high, and the carry should be gated with the clock. The synchronous chain is the intended usage.

Top module: `updn_stage`

## Requirements
- R1: While `clear_i` is high, `count_o` is zero at once, whatever the clock, `load_i`, `jam_i`, `cin_n_i` or `up_i` do.
- R2: While `load_i` is high and `clear_i` is low, `count_o` equals `jam_i` without any clock edge, and no clock edge in that time changes it.
- R3: With `clear_i`, `load_i` and `cin_n_i` low and `up_i` high, each rising clock edge adds one to the count, wrapping from all ones to zero.
- R4: With `clear_i`, `load_i` and `cin_n_i` low and `up_i` low, each rising clock edge subtracts one from the count, wrapping from zero to all ones.
- R5: With `cin_n_i` high and `clear_i`, `load_i` low, the count holds across clock edges.
- R6: `cout_n_o` is low exactly when `cin_n_i` is low and the count is at its terminal value, which is all ones when `up_i` is high and zero when `up_i` is low. It follows `cin_n_i` without a clock edge.
- R7: N stages on a shared clock, each `cout_n_o` wired to the next stage's `cin_n_i`, behave as one N*WIDTH-bit up/down counter with the same hold, wrap and carry rules.
- R8: Clear takes priority over load, and load takes priority over counting.
- R9: After clear or load is released, the count holds the cleared or loaded value until the next rising clock edge, where normal counting resumes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Count clock, rising edge active |
| clear_i | input | 1 | Level-sensitive clear to zero, highest priority |
| load_i | input | 1 | Level-sensitive parallel load from `jam_i` |
| jam_i | input | WIDTH | Parallel load value |
| cin_n_i | input | 1 | Active-low count enable / carry from the less significant stage |
| up_i | input | 1 | Direction: 1 counts up, 0 counts down |
| count_o | output | WIDTH | Current count |
| cout_n_o | output | 1 | Active-low terminal-count carry to the next stage |

## Verification
The bench builds the stage at its default WIDTH of 4 and chains three instances into a 12-bit counter. This keeps the state space at 4096 values, small enough to sweep completely in both directions, including the wrap at each end. Because there are three stages, a carry must cross two stage boundaries. That exposes the combinational enable-to-carry path. It also tests whether the middle stage advances only when the low stage wraps. A behavioural integer model of the whole 12-bit value is compared against all three stages and their carries after every clock. Mid-cycle probes check the asynchronous clear and load, and the enable-to-carry path, without any clock edge.

// File: rtl/updn_pkg.sv
package updn_pkg;

    // Operating mode of one stage, in priority order
    typedef enum logic [1:0] {
        MODE_CLEAR = 2'd0,
        MODE_LOAD  = 2'd1,
        MODE_STEP  = 2'd2,
        MODE_HOLD  = 2'd3
    } stage_mode_e;

endpackage

// File: rtl/updn_mode.sv
module updn_mode
    import updn_pkg::*;
(
    input  logic        clear_i,
    input  logic        load_i,
    input  logic        cin_n_i,
    output stage_mode_e mode_o
);
    // Clear beats load, load beats counting
    always_comb begin
        if (clear_i)      mode_o = MODE_CLEAR;
        else if (load_i)  mode_o = MODE_LOAD;
        else if (!cin_n_i) mode_o = MODE_STEP;
        else              mode_o = MODE_HOLD;
    end
endmodule

// File: rtl/updn_next.sv
module updn_next
    import updn_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  stage_mode_e      mode_i,
    input  logic             up_i,
    input  logic [WIDTH-1:0] cur_i,
    input  logic [WIDTH-1:0] jam_i,
    output logic [WIDTH-1:0] next_o
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    always_comb begin
        unique case (mode_i)
            MODE_CLEAR: next_o = '0;
            MODE_LOAD:  next_o = jam_i;
            MODE_STEP:  next_o = up_i ? (cur_i + ONE) : (cur_i - ONE);
            default:    next_o = cur_i;
        endcase
    end
endmodule

// File: rtl/updn_term.sv
module updn_term #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] cnt_i,
    input  logic             up_i,
    output logic             term_o
);
    // Terminal value: all ones going up, zero going down
    logic all_ones;
    logic all_zero;

    assign all_ones = &cnt_i;
    assign all_zero = ~|cnt_i;
    assign term_o   = up_i ? all_ones : all_zero;
endmodule

// File: rtl/updn_stage.sv
module updn_stage
    import updn_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             clear_i,
    input  logic             load_i,
    input  logic [WIDTH-1:0] jam_i,
    input  logic             cin_n_i,
    input  logic             up_i,
    output logic [WIDTH-1:0] count_o,
    output logic             cout_n_o
);
    typedef struct packed {
        logic [WIDTH-1:0] cnt;
    } stage_state_t;

    stage_state_t     state_d;
    stage_state_t     state_q;
    stage_mode_e      mode;
    logic [WIDTH-1:0] step_val;
    logic             at_term;

    updn_mode u_mode (
        .clear_i (clear_i),
        .load_i  (load_i),
        .cin_n_i (cin_n_i),
        .mode_o  (mode)
    );

    updn_next #(.WIDTH(WIDTH)) u_next (
        .mode_i (mode),
        .up_i   (up_i),
        .cur_i  (state_q.cnt),
        .jam_i  (jam_i),
        .next_o (step_val)
    );

    // Next-value process
    always_comb begin
        state_d     = state_q;
        state_d.cnt = step_val;
    end

    // Register process: clear and load act without the clock
    always_ff @(posedge clk or posedge clear_i or posedge load_i) begin
        if (clear_i) begin
            state_q <= '0;
        end else if (load_i) begin
            state_q.cnt <= jam_i;
        end else begin
            state_q <= state_d;
        end
    end

    // Visible count stays transparent to the level controls
    always_comb begin
        case (mode)
            MODE_CLEAR: count_o = '0;
            MODE_LOAD:  count_o = jam_i;
            default:    count_o = state_q.cnt;
        endcase
    end

    updn_term #(.WIDTH(WIDTH)) u_term (
        .cnt_i  (count_o),
        .up_i   (up_i),
        .term_o (at_term)
    );

    assign cout_n_o = ~(~cin_n_i & at_term);
endmodule

// File: rtl/updn_stage_chk.sv
module updn_stage_chk #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             clear_i,
    input logic             load_i,
    input logic [WIDTH-1:0] jam_i,
    input logic             cin_n_i,
    input logic             up_i,
    input logic [WIDTH-1:0] count_o,
    input logic             cout_n_o
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    // R3
    up_step_chk: assert property (@(posedge clk) disable iff (clear_i)
        (!load_i && !cin_n_i && up_i) |=>
        (load_i || clear_i || count_o == WIDTH'($past(count_o) + ONE)));

    // R4
    down_step_chk: assert property (@(posedge clk) disable iff (clear_i)
        (!load_i && !cin_n_i && !up_i) |=>
        (load_i || clear_i || count_o == WIDTH'($past(count_o) - ONE)));

    // R5
    hold_chk: assert property (@(posedge clk) disable iff (clear_i)
        (!load_i && cin_n_i) |=>
        (load_i || clear_i || $stable(count_o)));

    // R2
    load_follow_chk: assert property (@(posedge clk) disable iff (clear_i)
        load_i |-> (count_o == jam_i));

    // R6
    carry_gate_chk: assert property (@(posedge clk) disable iff (clear_i)
        cin_n_i |-> cout_n_o);

    // R6
    carry_term_chk: assert property (@(posedge clk) disable iff (clear_i)
        (!cin_n_i && up_i && count_o == '1) |-> !cout_n_o);
endmodule

bind updn_stage updn_stage_chk #(.WIDTH(WIDTH)) chk_i (
    .clk      (clk),
    .clear_i  (clear_i),
    .load_i   (load_i),
    .jam_i    (jam_i),
    .cin_n_i  (cin_n_i),
    .up_i     (up_i),
    .count_o  (count_o),
    .cout_n_o (cout_n_o)
);

// File: tb/updn_stage_tb_top.sv
module updn_stage_tb_top;
    localparam int W      = 4;
    localparam int NST    = 3;
    localparam int TOTW   = W * NST;
    localparam int MODV   = 1 << TOTW;

    logic             clk = 1'b0;
    logic             clear = 1'b1;
    logic             load = 1'b0;
    logic             en_n = 1'b1;
    logic             up = 1'b1;
    logic [TOTW-1:0]  jam = '0;
    logic [W-1:0]     cnt [NST];
    logic [NST-1:0]   cout_n;
    logic [NST-1:0]   cin_n;
    logic [TOTW-1:0]  full;

    int n_checks = 0;
    int n_errors = 0;
    int ref_val  = 0;
    bit monitor_on = 1'b0;

    always #5 clk = ~clk;

    assign cin_n = {cout_n[NST-2:0], en_n};
    assign full  = {cnt[2], cnt[1], cnt[0]};

    for (genvar k = 0; k < NST; k++) begin : g_stage
        updn_stage #(.WIDTH(W)) dut_i (
            .clk      (clk),
            .clear_i  (clear),
            .load_i   (load),
            .jam_i    (jam[W*k +: W]),
            .cin_n_i  (cin_n[k]),
            .up_i     (up),
            .count_o  (cnt[k]),
            .cout_n_o (cout_n[k])
        );
    end

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // expected carry of stage k from the reference value
    function automatic int exp_cout(input int k);
        int low_mask;
        int low;
        low_mask = (1 << (W * (k + 1))) - 1;
        low = ref_val & low_mask;
        if (en_n) return 1;
        if (up) return (low == low_mask) ? 0 : 1;
        return (low == 0) ? 0 : 1;
    endfunction

    // Reference model update and per-clock compare (R3 R4 R5 R7 R8 R9)
    always @(posedge clk) begin
        if (clear)      ref_val = 0;
        else if (load)  ref_val = int'(jam);
        else if (!en_n) ref_val = up ? (ref_val + 1) % MODV : (ref_val + MODV - 1) % MODV;
        #2;
        if (monitor_on) begin
            chk("R7 count", int'(full), ref_val);
            for (int k = 0; k < NST; k++) chk("R6 cout", int'(cout_n[k]), exp_cout(k));
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        // R1 reset state
        cycles(2);
        chk("R1 reset count", int'(full), 0);
        chk("R1 reset carry", int'(cout_n), 7);
        clear = 1'b0;
        monitor_on = 1'b1;

        // R3 full up sweep with wrap
        up = 1'b1; en_n = 1'b0;
        cycles(MODV + 5);

        // R5 hold
        en_n = 1'b1;
        cycles(6);
        chk("R5 held", int'(full), ref_val);

        // R4 full down sweep with wrap
        up = 1'b0; en_n = 1'b0;
        cycles(MODV + 7);

        // R2 async load mid-cycle, count stays put through an edge (R8)
        @(negedge clk);
        jam = 12'hA5C; load = 1'b1;
        #1 chk("R2 async load", int'(full), 'hA5C);
        cycles(2);
        chk("R8 load over count", int'(full), 'hA5C);
        load = 1'b0;
        #1 chk("R9 holds after load", int'(full), 'hA5C);
        @(posedge clk); #2;
        chk("R9 resumes down", int'(full), 'hA5B);

        // R1 clear over load (R8)
        @(negedge clk);
        load = 1'b1; jam = 12'h777;
        #1 clear = 1'b1;
        #1 chk("R8 clear over load", int'(full), 0);
        cycles(1);
        load = 1'b0;
        cycles(1);
        clear = 1'b0;
        #1 chk("R9 holds after clear", int'(full), 0);

        // R6 combinational carry chain at all ones going up
        en_n = 1'b1; up = 1'b1;
        @(negedge clk);
        jam = 12'hFFF; load = 1'b1;
        cycles(1);
        load = 1'b0;
        #1 chk("R6 carry gated", int'(cout_n[2]), 1);
        en_n = 1'b0;
        #1 chk("R6 carry through chain", int'(cout_n[2]), 0);
        @(posedge clk); #2;
        chk("R3 wrap to zero", int'(full), 0);

        // R4 down terminal at zero
        en_n = 1'b1; up = 1'b0;
        #1 chk("R6 down gated", int'(cout_n[2]), 1);
        en_n = 1'b0;
        #1 chk("R6 down terminal", int'(cout_n[2]), 0);
        @(posedge clk); #2;
        chk("R4 wrap to max", int'(full), MODV - 1);

        // R7 mid-count preset then run across a stage boundary
        @(negedge clk);
        up = 1'b1; jam = 12'h0FD; load = 1'b1;
        cycles(1);
        load = 1'b0;
        cycles(5);
        chk("R7 cascade crossing", int'(full), 'h102);

        cycles(3);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        #(200000 * 10);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule